// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative translation buffer. It turns a 32-bit virtual address into a physical address. Each entry describes two neighbouring pages, an even one and an odd one. A per-entry size mask sets how large those pages are. A lookup presents the virtual address, a read/write flag and the current 8-bit address-space tag. One clock edge later the block returns a two-bit result code, the physical address and a flag that says whether the page may be written.

Software fills the buffer through a write port that takes an entry index and a complete entry. An entry carries:
- a virtual tag;
- a size mask;
- an address-space tag and a global flag that ignores that tag;
- two frame bases;
- a valid bit and a dirty bit for each half.

Several entries may match the same address. The entry with the lowest index then wins. Segment decoding, exception entry and refill policy belong to the surrounding logic.

Top module: `tlbx_lookup`

## Requirements
- R1: An entry matches when its global flag is set or its stored address-space tag equals `lk_asid`, and its stored virtual tag equals `lk_vaddr` with every bit of the effective mask cleared. The effective mask is the entry's size mask ORed with 0x1FFF, so the smallest page is 4 KB and a pair covers 8 KB.
- R2: The half is chosen by the address bit at the highest set position of the effective mask. When that bit is 1 the odd half (frame base, valid[1], dirty[1]) is used. When it is 0 the even half (valid[0], dirty[0]) is used.
- R3: On a hit, `res_paddr` equals the chosen half's frame base ORed with `lk_vaddr` ANDed with the effective mask shifted right by one.
- R4: When the matching entry's chosen half has its valid bit clear, `res_code` is 2 (invalid).
- R5: A write (`lk_write`=1) to a valid half whose dirty bit is clear gives `res_code` 3 (clean-page write). A read of such a half is a hit. On a hit, `res_writable` equals the chosen dirty bit.
- R6: With no matching entry, `res_code` is 1 (miss). A permitted access gives `res_code` 0 (hit). For every code other than 0, `res_paddr` and `res_writable` are 0.
- R7: When several entries match, the one with the lowest index decides the result.
- R8: Outputs are registered: the result of the lookup presented in one cycle appears after that cycle's rising edge. An entry write is seen by lookups from the following cycle on. A lookup in the same cycle as a write to the same entry uses the old contents.
- R9: Synchronous active-low reset forces `res_code` to 1 and clears `res_paddr`, `res_writable` and every entry to all zeros. A cleared entry therefore matches tag 0 with address-space tag 0 and reports invalid. It misses for any other address-space tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_asid | input | 8 | Current address-space tag |
| wr_en | input | 1 | Load one entry this cycle |
| wr_idx | input | 4 | Index of entry to load |
| wr_vtag | input | 32 | Virtual tag of the pair |
| wr_mask | input | 32 | Page size mask |
| wr_asid | input | 8 | Owning address-space tag |
| wr_global | input | 1 | Match regardless of address-space tag |
| wr_pfn_even | input | 32 | Frame base of the even half |
| wr_pfn_odd | input | 32 | Frame base of the odd half |
| wr_valid | input | 2 | Valid bits, [0] even, [1] odd |
| wr_dirty | input | 2 | Dirty bits, [0] even, [1] odd |
| res_code | output | 2 | 0 hit, 1 miss, 2 invalid, 3 clean-page write |
| res_paddr | output | 32 | Translated address (0 unless hit) |
| res_writable | output | 1 | Page may be written (hit only) |

## Verification
An entry load and a lookup can land in the same cycle, and they can target the very entry being replaced. The bench provokes this by raising `wr_en` for entry 0 while presenting an address that entry 0 translates. The new contents carry a different odd frame and a set dirty bit. The result after that edge must still show the old frame with the page not writable. The same lookup held one more cycle must show the new frame as writable.

// File: rtl/tlbx_pkg.sv
// Package: shared types for the paired-page translation buffer.
// Assumes 32-bit virtual and physical addresses and 8-bit address-space tags.
package tlbx_pkg;
    localparam int VA_W       = 32;
    localparam int ASID_W     = 8;
    localparam int MIN_PG_BITS = 13;  // effective mask never below a 8 KB pair

    typedef enum logic [1:0] {
        RES_HIT     = 2'd0,
        RES_MISS    = 2'd1,
        RES_INVALID = 2'd2,
        RES_CLEAN   = 2'd3
    } res_code_e;

    typedef struct packed {
        logic [VA_W-1:0]   vtag;
        logic [VA_W-1:0]   pmask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [VA_W-1:0]   pfn_even;
        logic [VA_W-1:0]   pfn_odd;
        logic [1:0]        valid;
        logic [1:0]        dirty;
    } tlb_entry_t;
endpackage

// File: rtl/tlbx_entry_store.sv
// Module: register file holding all buffer entries.
// Assumes one write per cycle; an out-of-range index is dropped.
module tlbx_entry_store
    import tlbx_pkg::*;
#(
    parameter int NUM_ENT = 16,
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  tlb_entry_t               wr_data,
    output tlb_entry_t [NUM_ENT-1:0] ents
);
    // Clear on reset, otherwise load the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents <= '0;
        end else if (wr_en && (32'(wr_idx) < NUM_ENT)) begin
            ents[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/tlbx_match_cell.sv
// Module: compare one entry against a lookup and translate through it.
// Assumes the size mask holds contiguous low ones; low 13 bits are forced set.
module tlbx_match_cell
    import tlbx_pkg::*;
(
    input  tlb_entry_t        ent,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [ASID_W-1:0] asid,
    output logic              hit,
    output logic              half_valid,
    output logic              half_dirty,
    output logic [VA_W-1:0]   paddr
);
    localparam logic [VA_W-1:0] MIN_MASK = VA_W'((64'd1 << MIN_PG_BITS) - 1);

    logic [VA_W-1:0] emask;
    logic            odd;

    // Tag/tag-space compare, half selection and address composition.
    always_comb begin
        emask      = ent.pmask | MIN_MASK;
        hit        = (ent.glob || (ent.asid == asid)) && ((vaddr & ~emask) == ent.vtag);
        odd        = |(vaddr & emask & ~(emask >> 1));
        half_valid = odd ? ent.valid[1] : ent.valid[0];
        half_dirty = odd ? ent.dirty[1] : ent.dirty[0];
        paddr      = (odd ? ent.pfn_odd : ent.pfn_even) | (vaddr & (emask >> 1));
    end
endmodule

// File: rtl/tlbx_pick.sv
// Module: lowest-index priority select over the per-entry hit vector.
// Assumes nothing about how many hits are set.
module tlbx_pick #(
    parameter int NUM_ENT = 16,
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0] hits,
    output logic               any_hit,
    output logic [IDX_W-1:0]   sel_idx
);
    // Scan from the top so the lowest set index is left last.
    always_comb begin
        any_hit = |hits;
        sel_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (hits[i]) sel_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlbx_lookup.sv
// Module: top of the paired-page translation buffer.
// Combinational compare across all entries, registered result.
// Assumes the caller decides segment mapping and exception handling.
module tlbx_lookup
    import tlbx_pkg::*;
#(
    parameter int NUM_ENT = 16,
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       lk_vaddr,
    input  logic              lk_write,
    input  logic [7:0]        lk_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_vtag,
    input  logic [31:0]       wr_mask,
    input  logic [7:0]        wr_asid,
    input  logic              wr_global,
    input  logic [31:0]       wr_pfn_even,
    input  logic [31:0]       wr_pfn_odd,
    input  logic [1:0]        wr_valid,
    input  logic [1:0]        wr_dirty,
    output logic [1:0]        res_code,
    output logic [31:0]       res_paddr,
    output logic              res_writable
);
    tlb_entry_t                 wr_data;
    tlb_entry_t [NUM_ENT-1:0]   ents;
    logic [NUM_ENT-1:0]         c_hit, c_valid, c_dirty;
    logic [VA_W-1:0]            c_paddr [NUM_ENT];
    logic                       any_hit;
    logic [IDX_W-1:0]           sel_idx;
    res_code_e                  nxt_code;
    logic [VA_W-1:0]            nxt_paddr;
    logic                       nxt_wr;

    // Gather the write port into one entry word.
    always_comb begin
        wr_data = '{vtag: wr_vtag, pmask: wr_mask, asid: wr_asid, glob: wr_global,
                    pfn_even: wr_pfn_even, pfn_odd: wr_pfn_odd,
                    valid: wr_valid, dirty: wr_dirty};
    end

    tlbx_entry_store #(.NUM_ENT(NUM_ENT)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .ents(ents)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cell
        tlbx_match_cell u_cell (
            .ent(ents[g]), .vaddr(lk_vaddr), .asid(lk_asid),
            .hit(c_hit[g]), .half_valid(c_valid[g]), .half_dirty(c_dirty[g]),
            .paddr(c_paddr[g])
        );
    end

    tlbx_pick #(.NUM_ENT(NUM_ENT)) u_pick (
        .hits(c_hit), .any_hit(any_hit), .sel_idx(sel_idx)
    );

    // Classify the winning entry's half against the access kind.
    always_comb begin
        nxt_code  = RES_MISS;
        nxt_paddr = '0;
        nxt_wr    = 1'b0;
        if (any_hit) begin
            if (!c_valid[sel_idx]) begin
                nxt_code = RES_INVALID;
            end else if (lk_write && !c_dirty[sel_idx]) begin
                nxt_code = RES_CLEAN;
            end else begin
                nxt_code  = RES_HIT;
                nxt_paddr = c_paddr[sel_idx];
                nxt_wr    = c_dirty[sel_idx];
            end
        end
    end

    // Register the lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_code     <= RES_MISS;
            res_paddr    <= '0;
            res_writable <= 1'b0;
        end else begin
            res_code     <= nxt_code;
            res_paddr    <= nxt_paddr;
            res_writable <= nxt_wr;
        end
    end
endmodule

// File: rtl/tlbx_lookup_chk.sv
// Module: temporal checks on the buffer's result port, bound to the top.
// Assumes the result codes of tlbx_pkg.
module tlbx_lookup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_write,
    input logic [1:0]  res_code,
    input logic [31:0] res_paddr,
    input logic        res_writable
);
    AST_NONHIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_code != 2'd0) |-> (res_paddr == 32'd0 && !res_writable)); // R6
    AST_RESET_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (res_code == 2'd1 && !res_writable)); // R9
    AST_WRITE_HIT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lk_write) && res_code == 2'd0) |-> res_writable); // R5
    AST_CLEAN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_code == 2'd3) |-> $past(lk_write)); // R5
endmodule

bind tlbx_lookup tlbx_lookup_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_write(lk_write), .res_code(res_code),
    .res_paddr(res_paddr), .res_writable(res_writable)
);

// File: tb/tlbx_lookup_test.sv
// Bench for tlbx_lookup: vector table of lookups, then directed corner cases.
module tlbx_lookup_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_vtag = '0, wr_mask = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [1:0]  wr_valid = '0, wr_dirty = '0;
    logic [1:0]  res_code;
    logic [31:0] res_paddr;
    logic        res_writable;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tlbx_lookup uut (.*);

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [7:0]  asid;
        logic [1:0]  code;
        logic [31:0] pa;
        logic        w;
        logic [3:0]  req;
    } vec_t;

    // Codes: 0 hit, 1 miss, 2 invalid, 3 clean-page write.
    localparam vec_t VEC [15] = '{
        '{32'h0040_0123, 1'b0, 8'd5,    2'd0, 32'h0010_0123, 1'b1, 4'd3}, // R3 even half
        '{32'h0040_1ABC, 1'b1, 8'd5,    2'd3, 32'h0,         1'b0, 4'd5}, // R5 clean write
        '{32'h0040_1ABC, 1'b0, 8'd5,    2'd0, 32'h0020_0ABC, 1'b0, 4'd5}, // R5 clean read
        '{32'h0040_0010, 1'b1, 8'd5,    2'd0, 32'h0010_0010, 1'b1, 4'd5}, // R5 dirty write
        '{32'h0040_0010, 1'b0, 8'd6,    2'd0, 32'h0050_0010, 1'b1, 4'd1}, // R1 tag space
        '{32'h0040_0010, 1'b0, 8'd7,    2'd1, 32'h0,         1'b0, 4'd1}, // R1 tag space miss
        '{32'h1000_8004, 1'b0, 8'h77,   2'd0, 32'h0300_8004, 1'b1, 4'd2}, // R2 global, 64K even
        '{32'h1001_0004, 1'b0, 8'h77,   2'd2, 32'h0,         1'b0, 4'd4}, // R4 odd invalid
        '{32'h1002_0000, 1'b0, 8'h77,   2'd1, 32'h0,         1'b0, 4'd6}, // R6 beyond pair
        '{32'h0040_2000, 1'b0, 8'd5,    2'd1, 32'h0,         1'b0, 4'd6}, // R6 next pair
        '{32'h1000_FFFF, 1'b1, 8'd0,    2'd0, 32'h0300_FFFF, 1'b1, 4'd3}, // R3 wide offset
        '{32'h0000_1000, 1'b0, 8'd0,    2'd2, 32'h0,         1'b0, 4'd9}, // R9 cleared entry
        '{32'h0000_1000, 1'b0, 8'd1,    2'd1, 32'h0,         1'b0, 4'd9}, // R9 cleared, other tag
        '{32'h2000_0ABC, 1'b0, 8'd3,    2'd0, 32'h0700_0ABC, 1'b1, 4'd7}, // R7 lowest index
        '{32'h2000_1ABC, 1'b1, 8'd3,    2'd0, 32'h0710_0ABC, 1'b1, 4'd7}  // R7 odd half
    };

    task automatic check(string tag, logic [1:0] ec, logic [31:0] ep, logic ew);
        n_chk++;
        if (res_code !== ec || res_paddr !== ep || res_writable !== ew) begin
            n_fail++;
            $display("FAIL %s: got code=%0d pa=%h w=%0b, expected code=%0d pa=%h w=%0b",
                     tag, res_code, res_paddr, res_writable, ec, ep, ew);
        end
    endtask

    task automatic load(input logic [3:0] idx, input logic [31:0] vt, input logic [31:0] mk,
                        input logic [7:0] as, input logic gl, input logic [31:0] pe,
                        input logic [31:0] po, input logic [1:0] v, input logic [1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vtag = vt; wr_mask = mk; wr_asid = as;
        wr_global = gl; wr_pfn_even = pe; wr_pfn_odd = po; wr_valid = v; wr_dirty = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic wr, input logic [7:0] as);
        @(negedge clk);
        lk_vaddr = va; lk_write = wr; lk_asid = as;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset output", 2'd1, 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        load(4'd0, 32'h0040_0000, 32'h0,         8'd5, 1'b0, 32'h0010_0000, 32'h0020_0000, 2'b11, 2'b01);
        load(4'd1, 32'h1000_0000, 32'h0001_E000, 8'd9, 1'b1, 32'h0300_0000, 32'h0400_0000, 2'b01, 2'b11);
        load(4'd2, 32'h0040_0000, 32'h0,         8'd6, 1'b0, 32'h0050_0000, 32'h0060_0000, 2'b11, 2'b11);
        load(4'd3, 32'h2000_0000, 32'h0,         8'd0, 1'b1, 32'h0700_0000, 32'h0710_0000, 2'b11, 2'b11);
        load(4'd4, 32'h2000_0000, 32'h0,         8'd0, 1'b1, 32'h0800_0000, 32'h0810_0000, 2'b11, 2'b11);

        for (int i = 0; i < 15; i++) begin
            look(VEC[i].va, VEC[i].wr, VEC[i].asid);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].code, VEC[i].pa, VEC[i].w);
        end

        // R8: load entry 0 and look it up in the same cycle.
        @(negedge clk);
        lk_vaddr = 32'h0040_1ABC; lk_write = 1'b0; lk_asid = 8'd5;
        wr_en = 1'b1; wr_idx = 4'd0; wr_vtag = 32'h0040_0000; wr_mask = 32'h0;
        wr_asid = 8'd5; wr_global = 1'b0; wr_pfn_even = 32'h0010_0000;
        wr_pfn_odd = 32'h0990_0000; wr_valid = 2'b11; wr_dirty = 2'b11;
        @(posedge clk);
        #1;
        check("R8 same-cycle old contents", 2'd0, 32'h0020_0ABC, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        check("R8 next-cycle new contents", 2'd0, 32'h0990_0ABC, 1'b1);

        // R9: reset mid-run clears outputs and entries.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9 reset mid-run output", 2'd1, 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        look(32'h0040_0123, 1'b0, 8'd5);
        check("R9 entry cleared", 2'd1, 32'h0, 1'b0);
        look(32'h0000_0000, 1'b0, 8'd0);
        check("R9 zero entry invalid", 2'd2, 32'h0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule